// File: doc/BRIEF.md
# Receive Frame Acceptance Filter

This block watches the byte stream that a receive MAC hands to its buffering stage and, when the last byte of each frame arrives, decides whether the frame is kept or dropped. The decision rests on four things:

- The destination address, compared with a programmed 48-bit station address.
- Whether the destination is a group (multicast) address.
- Whether the frame is a MAC control frame, identified by its EtherType.
- The frame length, checked against a fixed minimum and a programmable maximum.

Each frame produces one verdict pulse, which carries an accept flag and a 2-bit reason code. The filter also keeps a saturating drop counter for each drop reason.

The station address arrives in two configuration words. The low word holds octets 0 to 3. The high word holds octets 4 and 5, together with the two discard enables: one for a foreign destination and one for a group destination. Clearing both enables gives promiscuous reception. The control-frame drop bit and the maximum length are separate inputs. The downstream buffer uses the verdict to commit or rewind the frame.

Top module: `rx_frame_filter`

## Requirements
- R1: One cycle after the valid end beat of an open frame, `verdict_valid_o` is high for exactly one cycle. It is low in every other cycle and during reset, and all counters read zero after reset.
- R2: Octet k of the destination is the k-th byte received. Station octets 0..3 are `cfg_addr_lo_i[8k+7:8k]`, octet 4 is `cfg_addr_hi_i[7:0]` and octet 5 is `cfg_addr_hi_i[15:8]`. A difference in any single octet is a mismatch.
- R3: With `cfg_addr_hi_i[16]` set, a frame whose destination is neither the station address nor broadcast (all ones) is dropped with reason 1.
- R4: With `cfg_addr_hi_i[17]` set, a frame whose first destination octet has bit 0 set, and which is not broadcast, is dropped with reason 2. Broadcast is accepted.
- R5: With `cfg_addr_hi_i[16]` and `cfg_addr_hi_i[17]` both clear, no destination value causes a drop.
- R6: With `cfg_ctrl_drop_i` set, a frame whose bytes 12 and 13 (counting from 0) are 0x88 and 0x08 is dropped with reason 2. With the bit clear, such a frame passes.
- R7: A frame of fewer than MIN_LEN bytes (default 60) is dropped with reason 3. A frame of exactly MIN_LEN bytes passes the length test.
- R8: A frame longer than `cfg_max_len_i` bytes is dropped with reason 3. A frame of exactly `cfg_max_len_i` bytes passes the length test.
- R9: When several drop causes apply, the reason is length (3) first, then address (1), then multicast/control (2). Reason 0 means accept, and `verdict_accept_o` is high exactly when a verdict carries reason 0.
- R10: Each drop increments the counter of its reason (1 to `cnt_addr_o`, 2 to `cnt_type_o`, 3 to `cnt_len_o`). The new value is visible in the cycle the verdict is shown. A counter at all ones stays there.
- R11: A start beat inside an open frame restarts the frame. An end beat with no open frame produces no verdict. Beats with `valid_i` low are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Byte beat qualifier |
| sof_i | input | 1 | First byte of a frame (with valid_i) |
| eof_i | input | 1 | Last byte of a frame (with valid_i) |
| data_i | input | 8 | Received byte |
| cfg_addr_lo_i | input | 32 | Station octets 0..3 |
| cfg_addr_hi_i | input | 18 | Octets 4, 5; bit 16 foreign-address discard; bit 17 group discard |
| cfg_ctrl_drop_i | input | 1 | Drop MAC control frames |
| cfg_max_len_i | input | LEN_W | Maximum accepted frame length in bytes |
| verdict_valid_o | output | 1 | Verdict pulse |
| verdict_accept_o | output | 1 | Frame kept |
| verdict_reason_o | output | 2 | 0 accept, 1 address, 2 multicast/control, 3 length |
| cnt_addr_o | output | CNT_W | Address drop count |
| cnt_type_o | output | CNT_W | Multicast/control drop count |
| cnt_len_o | output | CNT_W | Length drop count |

## Verification
The verdict and the matching counter step are both due on the first rising edge after the end beat. That end beat may be the same beat as the start, or may follow idle gaps.

The bench drives inputs just after a rising edge and compares every output on the falling edge. Its reference model consumes the beat present at that falling edge and produces the values expected at the next one. A verdict or a count that arrives a cycle early or late is therefore reported in the cycle it should have appeared.

// File: rtl/rff_pkg.sv
package rff_pkg;
  typedef enum logic [1:0] {
    RSN_OK   = 2'd0,
    RSN_ADDR = 2'd1,
    RSN_TYPE = 2'd2,
    RSN_LEN  = 2'd3
  } reason_e;

  localparam int unsigned DA_BYTES   = 6;
  localparam int unsigned ET_HI_IDX  = 12;
  localparam int unsigned ET_LO_IDX  = 13;
  localparam int unsigned IDX_W      = 16;
  localparam logic [15:0] CTRL_ETYPE = 16'h8808;

  typedef struct packed {
    logic [8*DA_BYTES-1:0] da;     // octet k at [8k+7:8k]
    logic [15:0]           etype;
    logic [IDX_W-1:0]      len;
  } hdr_t;
endpackage

// File: rtl/rff_hdr_capture.sv
module rff_hdr_capture
  import rff_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       valid_i,
  input  logic       sof_i,
  input  logic       eof_i,
  input  logic [7:0] data_i,
  output logic       done_o,
  output hdr_t       hdr_o
);
  logic                  in_frame_q;
  logic [IDX_W-1:0]      idx_q;
  logic [8*DA_BYTES-1:0] da_q;
  logic [15:0]           et_q;

  logic                  beat_first, beat_take;
  logic [IDX_W-1:0]      idx_cur, len_n;
  logic [8*DA_BYTES-1:0] da_n;
  logic [15:0]           et_n;

  assign beat_first = valid_i & sof_i;
  assign beat_take  = beat_first | (valid_i & in_frame_q);
  assign idx_cur    = beat_first ? '0 : idx_q;
  assign len_n      = (&idx_cur) ? idx_cur : idx_cur + 1'b1;

  // merge current beat so the end beat is visible to the decision
  always_comb begin
    da_n = beat_first ? '0 : da_q;
    et_n = beat_first ? '0 : et_q;
    if (beat_take) begin
      for (int k = 0; k < DA_BYTES; k++) begin
        if (idx_cur == IDX_W'(k)) da_n[8*k +: 8] = data_i;
      end
      if (idx_cur == IDX_W'(ET_HI_IDX)) et_n[15:8] = data_i;
      if (idx_cur == IDX_W'(ET_LO_IDX)) et_n[7:0]  = data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_frame_q <= 1'b0;
      idx_q      <= '0;
      da_q       <= '0;
      et_q       <= '0;
    end else if (beat_take) begin
      in_frame_q <= ~eof_i;
      idx_q      <= len_n;
      da_q       <= da_n;
      et_q       <= et_n;
    end
  end

  assign done_o    = beat_take & eof_i;
  assign hdr_o.da    = da_n;
  assign hdr_o.etype = et_n;
  assign hdr_o.len   = len_n;
endmodule

// File: rtl/rff_classify.sv
module rff_classify
  import rff_pkg::*;
#(
  parameter int unsigned LEN_W   = 14,
  parameter int unsigned MIN_LEN = 60
) (
  input  hdr_t                  hdr_i,
  input  logic [8*DA_BYTES-1:0] station_i,
  input  logic                  da_discard_i,
  input  logic                  mc_discard_i,
  input  logic                  ctrl_drop_i,
  input  logic [LEN_W-1:0]      max_len_i,
  output reason_e               reason_o
);
  logic is_bcast, is_own, is_group, is_ctrl, too_short, too_long;

  assign is_bcast  = &hdr_i.da;
  assign is_own    = (hdr_i.da == station_i);
  assign is_group  = hdr_i.da[0];
  assign is_ctrl   = (hdr_i.etype == CTRL_ETYPE);
  assign too_short = hdr_i.len < IDX_W'(MIN_LEN);
  assign too_long  = hdr_i.len > IDX_W'(max_len_i);

  always_comb begin
    if (too_short || too_long)                         reason_o = RSN_LEN;
    else if (da_discard_i && !is_bcast && !is_own)     reason_o = RSN_ADDR;
    else if ((mc_discard_i && is_group && !is_bcast) ||
             (ctrl_drop_i && is_ctrl))                 reason_o = RSN_TYPE;
    else                                               reason_o = RSN_OK;
  end
endmodule

// File: rtl/rff_drop_counters.sv
module rff_drop_counters
  import rff_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  hit_i,
  input  reason_e               reason_i,
  output logic [2:0][CNT_W-1:0] cnt_o
);
  for (genvar g = 0; g < 3; g++) begin : g_cnt
    logic [CNT_W-1:0] cnt_q;
    logic             inc;
    assign inc = hit_i && (reason_i == reason_e'(g + 1)) && !(&cnt_q);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  cnt_q <= '0;
      else if (inc) cnt_q <= cnt_q + 1'b1;
    end
    assign cnt_o[g] = cnt_q;
  end
endmodule

// File: rtl/rx_frame_filter.sv
module rx_frame_filter
  import rff_pkg::*;
#(
  parameter int unsigned LEN_W   = 14,
  parameter int unsigned MIN_LEN = 60,
  parameter int unsigned CNT_W   = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             sof_i,
  input  logic             eof_i,
  input  logic [7:0]       data_i,
  input  logic [31:0]      cfg_addr_lo_i,
  input  logic [17:0]      cfg_addr_hi_i,
  input  logic             cfg_ctrl_drop_i,
  input  logic [LEN_W-1:0] cfg_max_len_i,
  output logic             verdict_valid_o,
  output logic             verdict_accept_o,
  output logic [1:0]       verdict_reason_o,
  output logic [CNT_W-1:0] cnt_addr_o,
  output logic [CNT_W-1:0] cnt_type_o,
  output logic [CNT_W-1:0] cnt_len_o
);
  localparam int unsigned DA_W = 8 * DA_BYTES;

  logic                  done;
  hdr_t                  hdr;
  reason_e               reason;
  logic [DA_W-1:0]       station;
  logic [2:0][CNT_W-1:0] cnt;
  logic                  vld_q;
  reason_e               rsn_q;

  assign station = {cfg_addr_hi_i[15:0], cfg_addr_lo_i};

  rff_hdr_capture i_capture (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .sof_i  (sof_i),
    .eof_i  (eof_i),
    .data_i (data_i),
    .done_o (done),
    .hdr_o  (hdr)
  );

  rff_classify #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) i_classify (
    .hdr_i       (hdr),
    .station_i   (station),
    .da_discard_i(cfg_addr_hi_i[16]),
    .mc_discard_i(cfg_addr_hi_i[17]),
    .ctrl_drop_i (cfg_ctrl_drop_i),
    .max_len_i   (cfg_max_len_i),
    .reason_o    (reason)
  );

  rff_drop_counters #(.CNT_W(CNT_W)) i_counters (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hit_i   (done),
    .reason_i(reason),
    .cnt_o   (cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      rsn_q <= RSN_OK;
    end else begin
      vld_q <= done;
      if (done) rsn_q <= reason;
    end
  end

  assign verdict_valid_o  = vld_q;
  assign verdict_accept_o = vld_q && (rsn_q == RSN_OK);
  assign verdict_reason_o = vld_q ? rsn_q : RSN_OK;
  assign cnt_addr_o = cnt[0];
  assign cnt_type_o = cnt[1];
  assign cnt_len_o  = cnt[2];
endmodule

// File: rtl/rff_checker.sv
module rff_checker #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic             eof_i,
  input logic             verdict_valid_o,
  input logic             verdict_accept_o,
  input logic [1:0]       verdict_reason_o,
  input logic [CNT_W-1:0] cnt_addr_o,
  input logic [CNT_W-1:0] cnt_type_o,
  input logic [CNT_W-1:0] cnt_len_o
);
  AST_VERDICT_NEEDS_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    verdict_valid_o |-> $past(valid_i && eof_i)); // R1
  AST_ACCEPT_IFF_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    verdict_accept_o |-> (verdict_valid_o && verdict_reason_o == 2'd0)); // R9
  AST_ADDR_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_addr_o != $past(cnt_addr_o)) |-> (verdict_valid_o && verdict_reason_o == 2'd1)); // R10
  AST_TYPE_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_type_o != $past(cnt_type_o)) |-> (verdict_valid_o && verdict_reason_o == 2'd2)); // R10
  AST_LEN_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_len_o != $past(cnt_len_o)) |-> (verdict_valid_o && verdict_reason_o == 2'd3)); // R10
  AST_LEN_CNT_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&$past(cnt_len_o)) |-> (&cnt_len_o)); // R10
endmodule

bind rx_frame_filter rff_checker #(.CNT_W(CNT_W)) i_rff_checker (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .valid_i         (valid_i),
  .eof_i           (eof_i),
  .verdict_valid_o (verdict_valid_o),
  .verdict_accept_o(verdict_accept_o),
  .verdict_reason_o(verdict_reason_o),
  .cnt_addr_o      (cnt_addr_o),
  .cnt_type_o      (cnt_type_o),
  .cnt_len_o       (cnt_len_o)
);

// File: tb/test_rx_frame_filter.sv
`timescale 1ns/1ps
module test_rx_frame_filter;
  localparam int CW = 4;
  localparam logic [47:0] OWN   = 48'h5544_3322_1102;
  localparam logic [47:0] OTHER = 48'h6655_4433_2210;
  localparam logic [47:0] OCT5  = 48'h5A44_3322_1102;
  localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] GROUP = 48'h0100_005E_0001;

  logic clk = 0, rst_ni = 0;
  logic valid = 0, sof = 0, eof = 0;
  logic [7:0]  data = 0;
  logic [31:0] cfg_lo = OWN[31:0];
  logic [17:0] cfg_hi = {2'b00, OWN[47:32]};
  logic        ctrl_drop = 0;
  logic [13:0] max_len = 14'd1518;
  logic        v_o, a_o;
  logic [1:0]  r_o;
  logic [CW-1:0] ca_o, ct_o, cl_o;

  int checks = 0, errors = 0;
  string tag = "R1";
  bit finished = 0;

  always #2.5 clk = ~clk;

  rx_frame_filter #(.CNT_W(CW)) i_rx_frame_filter (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid), .sof_i(sof), .eof_i(eof),
    .data_i(data), .cfg_addr_lo_i(cfg_lo), .cfg_addr_hi_i(cfg_hi),
    .cfg_ctrl_drop_i(ctrl_drop), .cfg_max_len_i(max_len),
    .verdict_valid_o(v_o), .verdict_accept_o(a_o), .verdict_reason_o(r_o),
    .cnt_addr_o(ca_o), .cnt_type_o(ct_o), .cnt_len_o(cl_o)
  );

  // reference model state
  logic [7:0] mq[$];
  bit   mopen = 0;
  bit   ev = 0;
  int   er = 0;
  int   ecnt[4] = '{0, 0, 0, 0};

  task automatic chk(string t, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", t, act, exp, $time);
    end
  endtask

  function automatic int judge();
    int n = mq.size();
    bit bc = 1, own = 1;
    if (n < 60 || n > int'(max_len)) return 3;
    for (int i = 0; i < 6; i++) begin
      if (mq[i] != 8'hFF) bc = 0;
      if (mq[i] != {cfg_hi[15:0], cfg_lo}[8*i +: 8]) own = 0;
    end
    if (cfg_hi[16] && !bc && !own) return 1;
    if (cfg_hi[17] && mq[0][0] && !bc) return 2;
    if (ctrl_drop && mq[12] == 8'h88 && mq[13] == 8'h08) return 2;
    return 0;
  endfunction

  always @(negedge clk) begin
    if (!rst_ni) begin
      mq.delete(); mopen = 0; ev = 0; er = 0; ecnt = '{0, 0, 0, 0};
      chk("R1 reset valid", int'(v_o), 0);
      chk("R10 reset counters", int'(ca_o) + int'(ct_o) + int'(cl_o), 0);
    end else begin
      chk("R1 verdict timing", int'(v_o), int'(ev));
      if (ev) begin
        chk({tag, " reason"}, int'(r_o), er);
        chk({tag, " R9 accept"}, int'(a_o), int'(er == 0));
      end
      chk("R10 cnt_addr", int'(ca_o), ecnt[1]);
      chk("R10 cnt_type", int'(ct_o), ecnt[2]);
      chk("R10 cnt_len", int'(cl_o), ecnt[3]);
      ev = 0;
      if (valid) begin
        if (sof) begin mq.delete(); mq.push_back(data); mopen = 1; end
        else if (mopen) mq.push_back(data);
        if (eof && mopen) begin
          er = judge(); ev = 1; mopen = 0;
          if (er != 0 && ecnt[er] < (1 << CW) - 1) ecnt[er]++;
        end
      end
    end
  end

  task automatic beat(logic [7:0] d, logic s, logic e, logic v);
    @(posedge clk); #1;
    data = d; sof = s; eof = e; valid = v;
  endtask

  task automatic frame(logic [47:0] da, logic [15:0] et, int n, bit gaps = 0);
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      if (i < 6) b = da[8*i +: 8];
      else if (i == 12) b = et[15:8];
      else if (i == 13) b = et[7:0];
      else b = 8'(i);
      beat(b, i == 0, i == n - 1, 1);
      if (gaps && i % 3 == 1 && i != n - 1) beat(8'hEE, 0, 0, 0);
    end
    beat(8'h00, 0, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1;
    repeat (2) @(posedge clk);
    // R3 / R2: address discard only
    tag = "R3"; cfg_hi = {2'b01, OWN[47:32]};
    frame(OWN, 16'h0800, 64);
    frame(OTHER, 16'h0800, 64);
    frame(BCAST, 16'h0800, 64);
    tag = "R2"; frame(OCT5, 16'h0800, 64);
    frame({OWN[47:8], 8'h03}, 16'h0800, 64);
    // R4: group discard only
    tag = "R4"; cfg_hi = {2'b10, OWN[47:32]};
    frame(GROUP, 16'h0800, 64);
    frame(BCAST, 16'h0800, 64);
    frame(OTHER, 16'h0800, 64);
    // R5: promiscuous
    tag = "R5"; cfg_hi = {2'b00, OWN[47:32]};
    frame(OTHER, 16'h0800, 64);
    frame(GROUP, 16'h0800, 64);
    // R6: control frames
    tag = "R6"; ctrl_drop = 1;
    frame(OWN, 16'h8808, 64);
    frame(OWN, 16'h0800, 64);
    ctrl_drop = 0;
    frame(OWN, 16'h8808, 64);
    // R7: minimum length
    tag = "R7";
    frame(OWN, 16'h0800, 59);
    frame(OWN, 16'h0800, 60);
    frame(OWN, 16'h0800, 1);
    // R8: maximum length
    tag = "R8"; max_len = 14'd100;
    frame(OWN, 16'h0800, 100);
    frame(OWN, 16'h0800, 101);
    max_len = 14'd1518;
    // R9: priority
    tag = "R9"; cfg_hi = {2'b11, OWN[47:32]}; ctrl_drop = 1;
    frame(OTHER, 16'h0800, 30);
    frame({OTHER[47:8], 8'h11}, 16'h8808, 64);
    frame(GROUP, 16'h8808, 64);
    // R11: restart, stray end, idle gaps, back to back
    tag = "R11"; cfg_hi = {2'b01, OWN[47:32]}; ctrl_drop = 0;
    for (int i = 0; i < 20; i++) beat(OTHER[8*(i%6) +: 8], i == 0, 0, 1);
    frame(OWN, 16'h0800, 64);
    beat(8'h12, 0, 1, 1);
    beat(8'h00, 0, 0, 0);
    beat(8'h00, 0, 1, 0);
    beat(8'h00, 0, 0, 0);
    frame(OWN, 16'h0800, 60, 1);
    for (int i = 0; i < 60; i++) beat(8'(i), i == 0, i == 59, 1);
    for (int i = 0; i < 64; i++) beat(OTHER[8*(i%6) +: 8], i == 0, i == 63, 1);
    beat(8'h00, 0, 0, 0);
    // R10: saturation of the length counter
    tag = "R10";
    for (int k = 0; k < 17; k++) frame(OWN, 16'h0800, 10);
    @(negedge clk);
    chk("R10 saturated cnt_len", int'(cl_o), (1 << CW) - 1);
    repeat (3) @(posedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule